// File: doc/BRIEF.md
# Transfer Descriptor Status Writeback Unit

This unit works out the new control/status word of a USB transfer descriptor once a bus transaction on it has been attempted. For each accepted request it takes the descriptor's current control word, its token word, a result code and the number of bytes actually moved. One clock later it returns the updated control word, a write-enable that says whether memory needs that word written back, a two-bit interrupt mask, and flags for frame abort, USB error and short packet. It also returns a result code: advance to the next element, skip (the descriptor failed or is still pending), or abort the frame.

A descriptor walker uses it between fetching a descriptor and writing it back. The result code steers the walk through the queue. The interrupt mask is merged into the controller's end-of-frame interrupt state. Fetching descriptors, moving data and emulating devices belong to other blocks.

Top module: `td_status_wb`

## Requirements
- R1: After a synchronous active-high reset, `out_valid`, `ctrl_out`, `ctrl_we`, `int_mask`, `frame_abort`, `usb_err`, `short_pkt` and `ret_code` are all zero. Each request with `in_valid` high produces exactly one result, with `out_valid` high, on the next clock edge.
- R2: The maximum length is token bits 31:21 plus one, modulo 2048, so 0x7FF encodes zero bytes. On a success result (`result_in`=0), control bits 10:0 become (actual length − 1) mod 2048. Active (bit 23) and NAK (bit 19) are cleared. `ret_code` is 2'b00 (advance).
- R3: When the token PID is IN (0x69) and the actual length is greater than the maximum length, a success result is turned into babble. The length field is still written, babble (bit 20) and stalled (bit 22) are set, active is cleared, `frame_abort` is high and `ret_code` is 2'b11.
- R4: On success, when short-packet-detect (bit 29) is set and the actual length is below the maximum length, `short_pkt` and `int_mask[1]` are high and `ret_code` is 2'b01 (do not advance). When the actual length equals the maximum length, there is no short packet.
- R5: A stall result (`result_in`=1) sets stalled, clears active and gives `ret_code` 2'b01.
- R6: A babble result (`result_in`=2) sets babble and stalled, clears active, raises `frame_abort` and gives `ret_code` 2'b11.
- R7: A NAK result (`result_in`=3) on a non-SETUP token sets the NAK bit, leaves active set, raises no interrupt and gives `ret_code` 2'b01.
- R8: A timeout result (`result_in`=4) sets bit 18. A non-zero error count (bits 28:27) is decremented. When the count reaches zero, active is cleared and `usb_err` is raised. A count that is already zero stays zero and the descriptor stays active. `ret_code` is 2'b01.
- R9: A NAK on a SETUP token (PID 0x2D) sets the NAK bit and is then handled exactly like a timeout (R8).
- R10: `int_mask[0]` is high exactly when interrupt-on-complete (bit 24) is set and the output word has active cleared.
- R11: A descriptor whose input active bit is clear is left unchanged: `ctrl_we` is 0, no flag or mask bit is raised, and `ret_code` is 2'b01.
- R12: `ctrl_we` is high exactly when `ctrl_out` differs from the `ctrl_in` of the same request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| ctrl_in | input | 32 | Descriptor control/status word |
| token_in | input | 32 | Descriptor token word |
| result_in | input | 3 | 0 success, 1 stall, 2 babble, 3 NAK, 4 timeout |
| act_len_in | input | 12 | Bytes actually transferred |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| ctrl_out | output | 32 | Updated control/status word |
| ctrl_we | output | 1 | Write back ctrl_out |
| int_mask | output | 2 | Bit 0 completion interrupt, bit 1 short-packet interrupt |
| frame_abort | output | 1 | Stop processing the current frame |
| usb_err | output | 1 | Error count ran out |
| short_pkt | output | 1 | Short packet detected |
| ret_code | output | 2 | 00 advance, 01 skip, 11 abort |

## Verification
Some properties are checked on every cycle. The write-enable must always match a real change against the registered input word. A frame abort must always come with both babble and stalled set. A USB error and a completion interrupt may only appear on a retired descriptor. An inactive input must never be written back. Only the bench scenarios can show the arithmetic: the minus-one length encodings, including the zero-byte code, the error countdown from each starting count, the SETUP-NAK redirect and the short-packet boundary at equal lengths.

// File: rtl/td_wb_pkg.sv
package td_wb_pkg;
  localparam int CW        = 32;
  localparam int B_SPD     = 29;
  localparam int B_ERR_HI  = 28;
  localparam int B_ERR_LO  = 27;
  localparam int B_IOC     = 24;
  localparam int B_ACT     = 23;
  localparam int B_STALL   = 22;
  localparam int B_BABBLE  = 20;
  localparam int B_NAK     = 19;
  localparam int B_TMO     = 18;

  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_SETUP = 8'h2D;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_STALL   = 3'd1,
    RES_BABBLE  = 3'd2,
    RES_NAK     = 3'd3,
    RES_TIMEOUT = 3'd4
  } td_result_e;

  typedef enum logic [1:0] {
    RET_ADV   = 2'b00,
    RET_SKIP  = 2'b01,
    RET_ABORT = 2'b11
  } td_ret_e;
endpackage

// File: rtl/td_token_decode.sv
module td_token_decode #(
  parameter int LEN_W   = 11,
  parameter int LEN_LSB = 21
) (
  input  logic [31:0]      token,
  output logic [LEN_W-1:0] max_len,
  output logic             is_in,
  output logic             is_setup
);
  import td_wb_pkg::*;

  logic [7:0] pid;
  logic       unused_addr_ep;

  assign pid            = token[7:0];
  assign max_len        = token[LEN_LSB +: LEN_W] + LEN_W'(1);
  assign is_in          = (pid == PID_IN);
  assign is_setup       = (pid == PID_SETUP);
  assign unused_addr_ep = ^token[LEN_LSB-1:8];
endmodule

// File: rtl/td_status_calc.sv
module td_status_calc #(
  parameter int LEN_W = 11
) (
  input  logic [31:0]        ctrl_in,
  input  logic [LEN_W-1:0]   max_len,
  input  logic               is_in,
  input  logic               is_setup,
  input  td_wb_pkg::td_result_e result,
  input  logic [LEN_W:0]     act_len,
  output logic [31:0]        ctrl_new,
  output logic [1:0]         mask,
  output logic               abort,
  output logic               err_out,
  output logic               shrt,
  output td_wb_pkg::td_ret_e ret
);
  import td_wb_pkg::*;

  td_result_e eff;
  logic [1:0] errcnt;

  always_comb begin
    ctrl_new = ctrl_in;
    mask     = 2'b00;
    abort    = 1'b0;
    err_out  = 1'b0;
    shrt     = 1'b0;
    ret      = RET_SKIP;
    eff      = result;
    errcnt   = ctrl_in[B_ERR_HI:B_ERR_LO];
    if (ctrl_in[B_ACT]) begin
      if (eff == RES_OK) begin
        ctrl_new[LEN_W-1:0] = act_len[LEN_W-1:0] - LEN_W'(1);
        ctrl_new[B_ACT]     = 1'b0;
        ctrl_new[B_NAK]     = 1'b0;
        if (is_in && (act_len > {1'b0, max_len})) begin
          eff = RES_BABBLE;
        end else if (ctrl_in[B_SPD] && (act_len < {1'b0, max_len})) begin
          shrt    = 1'b1;
          mask[1] = 1'b1;
          ret     = RET_SKIP;
        end else begin
          ret = RET_ADV;
        end
      end
      if (eff == RES_NAK) begin
        ctrl_new[B_NAK] = 1'b1;
        if (is_setup) eff = RES_TIMEOUT;
      end
      if (eff == RES_STALL) begin
        ctrl_new[B_STALL] = 1'b1;
        ctrl_new[B_ACT]   = 1'b0;
      end
      if (eff == RES_BABBLE) begin
        ctrl_new[B_BABBLE] = 1'b1;
        ctrl_new[B_STALL]  = 1'b1;
        ctrl_new[B_ACT]    = 1'b0;
        abort              = 1'b1;
        ret                = RET_ABORT;
      end
      if (eff == RES_TIMEOUT) begin
        ctrl_new[B_TMO] = 1'b1;
        if (errcnt != 2'd0) begin
          errcnt = errcnt - 2'd1;
          if (errcnt == 2'd0) begin
            ctrl_new[B_ACT] = 1'b0;
            err_out         = 1'b1;
          end
        end
        ctrl_new[B_ERR_HI:B_ERR_LO] = errcnt;
      end
      if (ctrl_in[B_IOC] && !ctrl_new[B_ACT]) mask[0] = 1'b1;
    end
  end
endmodule

// File: rtl/td_status_wb.sv
module td_status_wb #(
  parameter int LEN_W   = 11,
  parameter int LEN_LSB = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [31:0]      ctrl_in,
  input  logic [31:0]      token_in,
  input  logic [2:0]       result_in,
  input  logic [LEN_W:0]   act_len_in,
  output logic             out_valid,
  output logic [31:0]      ctrl_out,
  output logic             ctrl_we,
  output logic [1:0]       int_mask,
  output logic             frame_abort,
  output logic             usb_err,
  output logic             short_pkt,
  output logic [1:0]       ret_code
);
  import td_wb_pkg::*;

  logic [LEN_W-1:0] max_len;
  logic             is_in, is_setup;
  logic [31:0]      ctrl_new;
  logic [1:0]       mask_n;
  logic             abort_n, err_n, shrt_n;
  td_ret_e          ret_n;

  td_token_decode #(.LEN_W(LEN_W), .LEN_LSB(LEN_LSB)) u_dec (
    .token(token_in), .max_len(max_len), .is_in(is_in), .is_setup(is_setup)
  );

  td_status_calc #(.LEN_W(LEN_W)) u_calc (
    .ctrl_in(ctrl_in), .max_len(max_len), .is_in(is_in), .is_setup(is_setup),
    .result(td_result_e'(result_in)), .act_len(act_len_in),
    .ctrl_new(ctrl_new), .mask(mask_n), .abort(abort_n), .err_out(err_n),
    .shrt(shrt_n), .ret(ret_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      ctrl_out    <= '0;
      ctrl_we     <= 1'b0;
      int_mask    <= 2'b00;
      frame_abort <= 1'b0;
      usb_err     <= 1'b0;
      short_pkt   <= 1'b0;
      ret_code    <= 2'b00;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ctrl_out    <= ctrl_new;
        ctrl_we     <= (ctrl_new != ctrl_in);
        int_mask    <= mask_n;
        frame_abort <= abort_n;
        usb_err     <= err_n;
        short_pkt   <= shrt_n;
        ret_code    <= ret_n;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R12
  we_change_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (ctrl_we == (ctrl_out != $past(ctrl_in))));

  // R6
  abort_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && frame_abort) |-> (ctrl_out[B_BABBLE] && ctrl_out[B_STALL]
                                    && !ctrl_out[B_ACT] && ret_code == 2'b11));

  // R8
  err_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && usb_err) |-> (!ctrl_out[B_ACT] && ctrl_out[B_TMO]
                                && ctrl_out[B_ERR_HI:B_ERR_LO] == 2'd0));

  // R10
  ioc_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && int_mask[0]) |-> ($past(ctrl_in[B_IOC]) && !ctrl_out[B_ACT]));

  // R11
  inactive_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(ctrl_in[B_ACT])) |-> (!ctrl_we && int_mask == 2'b00
                                               && !frame_abort && !usb_err));
endmodule

// File: tb/td_status_wb_test.sv
module td_status_wb_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] ctrl_in = '0;
  logic [31:0] token_in = '0;
  logic [2:0]  result_in = '0;
  logic [11:0] act_len_in = '0;
  logic        out_valid, ctrl_we, frame_abort, usb_err, short_pkt;
  logic [31:0] ctrl_out;
  logic [1:0]  int_mask, ret_code;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [39:0] v;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  td_status_wb uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ctrl_in(ctrl_in),
    .token_in(token_in), .result_in(result_in), .act_len_in(act_len_in),
    .out_valid(out_valid), .ctrl_out(ctrl_out), .ctrl_we(ctrl_we),
    .int_mask(int_mask), .frame_abort(frame_abort), .usb_err(usb_err),
    .short_pkt(short_pkt), .ret_code(ret_code)
  );

  // Expected result packed as {ctrl, we, mask, abort, err, short, ret}
  function automatic logic [39:0] model(input logic [31:0] c0, input logic [31:0] tk,
                                        input int res, input int act);
    logic [31:0] c = c0;
    logic [1:0]  m = 2'b00;
    logic        ab = 0, ue = 0, sp = 0;
    logic [1:0]  rc = 2'b01;
    int          mx = (int'(tk[31:21]) + 1) % 2048;
    int          r = res;
    int          e = int'(c0[28:27]);
    if (c0[23]) begin
      if (r == 0) begin
        c[10:0] = 11'((act + 2047) % 2048);
        c[23] = 0; c[19] = 0;
        if (tk[7:0] == 8'h69 && act > mx) r = 2;
        else if (c0[29] && act < mx) begin sp = 1; m[1] = 1; end
        else rc = 2'b00;
      end
      if (r == 3 && tk[7:0] == 8'h2D) begin c[19] = 1; r = 4; end
      case (r)
        1: begin c[22] = 1; c[23] = 0; end
        2: begin c[20] = 1; c[22] = 1; c[23] = 0; ab = 1; rc = 2'b11; end
        3: c[19] = 1;
        4: begin
          c[18] = 1;
          if (e > 0) begin
            e = e - 1;
            if (e == 0) begin c[23] = 0; ue = 1; end
          end
          c[28:27] = 2'(e);
        end
        default: ;
      endcase
      if (c0[24] && !c[23]) m[0] = 1;
    end
    return {c, (c != c0), m, ab, ue, sp, rc};
  endfunction

  task automatic send(input logic [31:0] c, input logic [31:0] tk, input int res,
                      input int act, input string req);
    exp_t e;
    @(negedge clk);
    ctrl_in = c; token_in = tk; result_in = 3'(res); act_len_in = 12'(act);
    in_valid = 1'b1;
    e.v = model(c, tk, res, act);
    e.req = req;
    sb.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      logic [39:0] got;
      exp_t e;
      got = {ctrl_out, ctrl_we, int_mask, frame_abort, usb_err, short_pkt, ret_code};
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL unexpected result: actual %h expected none", got);
      end else begin
        e = sb.pop_front();
        if (got !== e.v) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", e.req, got, e.v);
        end
      end
    end
  end

  function automatic logic [31:0] tok(input logic [7:0] pid, input int maxf);
    return {11'(maxf), 6'd3, 7'd5, pid};
  endfunction

  localparam logic [31:0] ACT = 32'h0080_0000;
  localparam logic [31:0] IOC = 32'h0100_0000;
  localparam logic [31:0] SPD = 32'h2000_0000;
  localparam logic [31:0] NAKB = 32'h0008_0000;
  function automatic logic [31:0] errc(input int n); return {3'b0, 2'(n), 27'b0}; endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if ({out_valid, ctrl_out, ctrl_we, int_mask, frame_abort, usb_err, short_pkt, ret_code} !== '0) begin
      fails++;
      $display("FAIL R1 reset: actual %h expected 0",
               {out_valid, ctrl_out, ctrl_we, int_mask, frame_abort, usb_err, short_pkt, ret_code});
    end
    send(ACT | IOC | errc(3) | NAKB | 32'h7FF, tok(8'hE1, 7), 0, 8, "R2 R10 OUT success");
    send(ACT | errc(3), tok(8'h69, 7), 0, 0, "R2 IN zero bytes");
    send(ACT | 32'h7FF, tok(8'hE1, 11'h7FF), 0, 0, "R2 zero max length");
    send(ACT | IOC | errc(2), tok(8'h69, 7), 0, 9, "R3 IN overrun to babble");
    send(ACT | IOC | SPD | errc(3), tok(8'h69, 7), 0, 5, "R4 short packet");
    send(ACT | SPD | errc(3), tok(8'h69, 7), 0, 8, "R4 full length no short");
    send(ACT | IOC | errc(3), tok(8'hE1, 3), 1, 0, "R5 stall");
    send(ACT | errc(1), tok(8'h69, 3), 2, 0, "R6 babble");
    send(ACT | IOC | errc(3), tok(8'hE1, 3), 3, 0, "R7 NAK keeps active");
    send(ACT | NAKB | errc(3), tok(8'h69, 3), 3, 0, "R12 NAK no change");
    send(ACT | IOC | errc(3), tok(8'hE1, 3), 4, 0, "R8 timeout 3 to 2");
    send(ACT | IOC | errc(1), tok(8'hE1, 3), 4, 0, "R8 timeout retire");
    send(ACT | errc(0), tok(8'hE1, 3), 4, 0, "R8 timeout count zero");
    send(ACT | errc(2), tok(8'h2D, 7), 3, 0, "R9 SETUP NAK countdown");
    send(ACT | IOC | errc(1), tok(8'h2D, 7), 3, 0, "R9 SETUP NAK retire");
    send(IOC | errc(3) | 32'h123, tok(8'h69, 7), 2, 0, "R11 inactive descriptor");
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R1 missing results: actual %0d pending expected 0", sb.size());
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule